// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Engine with Clock Suspend

This block is the column-side burst logic of a synchronous DRAM device. Once a row is assumed open, it takes READ and WRITE commands carrying a start column, walks through the columns of a burst, and moves data between the DQ pins and a small register-file array. A mode-set command programs the burst length, the column ordering, the read latency, and a flag that turns every WRITE into a single-column access while READs keep bursting.

A clock-enable input lets the host pause a burst in progress. The input is registered on every rising edge. When that registered value is low and a column access is under way, the next internal edge is skipped. On a skipped edge the column counter, the read data pipeline and command capture all hold, and the read data on the output stays driven. When no access is under way, a low clock-enable has no effect.

A READ or WRITE that arrives during a burst cuts the old burst short and starts a new one at the new column. Read words that have already been fetched still leave the pipeline in order.

Top module: `sdram_colburst`

## Requirements
- R1: After reset, rdata_oe is 0 and rdata is 0. The mode is burst length 1, sequential order, read latency 2, single-write off. Every array location is 0.
- R2: Command codes on cmd are 0 NOP, 1 READ, 2 WRITE and 3 MODE-SET. A MODE-SET loads the mode from addr: addr[1:0] is the length code (0, 1, 2, 3 give 1, 2, 4, 8 words), addr[2]=1 selects interleaved order, addr[4]=1 selects read latency 3 (otherwise 2), and addr[9]=1 selects single-column writes.
- R3: For a READ accepted on internal edge E, word k of the burst is on rdata with rdata_oe=1 from internal edge E+CL+k until the next internal edge, where CL is the read latency. When no word is presented, rdata_oe is 0 and rdata is 0.
- R4: Word k of a burst of length L starting at column S uses column (S with its low log2(L) bits replaced by an offset). The offset is (S mod L + k) mod L in sequential order and (S mod L) XOR k in interleaved order.
- R5: For a WRITE accepted on internal edge E, the value on wdata at internal edge E+k is stored at the column of word k. rdata_oe stays 0 during a write burst that follows an idle pipeline.
- R6: With single-column writes selected, a WRITE stores only the word given with the command, whatever the burst length. READs still use the full burst length.
- R7: A READ or WRITE accepted during an active burst ends that burst and starts a new one at its own column. Read words fetched before it still appear at their scheduled edges.
- R8: When clk rises with cke low while a burst or read fetch is pending, the following edge is suspended: the column position does not advance, no word is fetched or stored, and rdata and rdata_oe hold their values. Operation resumes on the first edge after cke is registered high.
- R9: A command, address or wdata present at a suspended edge is ignored.
- R10: When no burst is active and no read word is pending, a low registered cke does not block a command on the next edge.

Here CL is 2 or 3. The array has 2^COL_W words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, registered every edge |
| cmd | input | 2 | Command code (R2) |
| addr | input | 10 | Start column in the low COL_W bits, or mode word for MODE-SET |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| rdata_oe | output | 1 | High while rdata carries a burst word |

## Verification
The embedded properties take for granted that MODE-SET is issued only when nothing is in flight, because a latency change during a drain has no defined outcome. They also take for granted that a burst is not interrupted while the read pipeline is still draining a different latency. The stimulus issues MODE-SET only after each read has been observed to finish. It lowers cke only on edges where the bench's own count of internal edges shows fetches or stores still pending. On every suspended edge it places a random READ or WRITE and random data on the pins, so any capture would corrupt later readback. A directed idle case with cke low checks that commands still get through.

// File: rtl/sdram_colburst.sv
module sdram_colburst #(
  parameter int DW    = 16,
  parameter int COL_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic [1:0]    cmd,
  input  logic [9:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);

  localparam int DEPTH = 1 << COL_W;
  localparam logic [1:0] C_NOP  = 2'd0;
  localparam logic [1:0] C_RD   = 2'd1;
  localparam logic [1:0] C_WR   = 2'd2;
  localparam logic [1:0] C_MODE = 2'd3;

  logic             cke_q;
  logic [1:0]       m_lc;
  logic             m_il, m_cl3, m_ws;
  logic             active, is_wr;
  logic [COL_W-1:0] start;
  logic [2:0]       cnt;
  logic [DW-1:0]    mem [DEPTH];
  logic             v1, v2, v3;
  logic [DW-1:0]    d1, d2, d3;

  logic unused_bits;
  assign unused_bits = ^{addr[8:5], addr[3]};

  function automatic logic [COL_W-1:0] col_at(input logic [COL_W-1:0] base,
                                              input logic [2:0] k,
                                              input logic [2:0] msk,
                                              input logic il);
    logic [2:0] so, off;
    so  = base[2:0] & msk;
    off = (il ? (so ^ k) : (so + k)) & msk;
    return (base & ~COL_W'(msk)) | COL_W'(off);
  endfunction

  wire [3:0] blen    = 4'd1 << m_lc;
  wire [2:0] bmask   = 3'(blen - 4'd1);
  wire       busy    = active | v1 | v2 | (m_cl3 & v3);
  wire       freeze  = ~cke_q & busy;
  wire       accept  = ~freeze;
  wire       new_rw  = accept & ((cmd == C_RD) | (cmd == C_WR));
  wire [COL_W-1:0] cur_col = new_rw ? addr[COL_W-1:0] : col_at(start, cnt, bmask, m_il);
  wire       cont    = accept & (cmd == C_NOP) & active;
  wire       do_rd   = (accept & (cmd == C_RD)) | (cont & ~is_wr);
  wire       do_wr   = (accept & (cmd == C_WR)) | (cont & is_wr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lc   <= 2'd0;
      m_il   <= 1'b0;
      m_cl3  <= 1'b0;
      m_ws   <= 1'b0;
      active <= 1'b0;
      is_wr  <= 1'b0;
      start  <= '0;
      cnt    <= 3'd0;
    end else if (accept) begin
      case (cmd)
        C_MODE: begin
          m_lc   <= addr[1:0];
          m_il   <= addr[2];
          m_cl3  <= addr[4];
          m_ws   <= addr[9];
          active <= 1'b0;
        end
        C_RD, C_WR: begin
          start  <= addr[COL_W-1:0];
          is_wr  <= (cmd == C_WR);
          cnt    <= 3'd1;
          active <= !((m_lc == 2'd0) || ((cmd == C_WR) && m_ws));
        end
        default: begin
          if (active) begin
            cnt <= cnt + 3'd1;
            if (cnt == bmask) active <= 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (do_wr) begin
      mem[cur_col] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      d1 <= '0;   d2 <= '0;   d3 <= '0;
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else if (accept) begin
      v1 <= do_rd;
      d1 <= mem[cur_col];
      v2 <= v1;
      d2 <= d1;
      v3 <= v2;
      d3 <= d2;
      rdata_oe <= m_cl3 ? v3 : v2;
      rdata    <= m_cl3 ? (v3 ? d3 : '0) : (v2 ? d2 : '0);
    end
  end

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(rdata) && $stable(rdata_oe) && $stable(cnt) && $stable(active));

  p_ignore_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(start) && $stable(is_wr) && $stable(m_lc) && $stable(m_cl3));

  p_single_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == C_WR && m_ws) |=> !active);

  p_cnt_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt != 3'd0) && (cnt <= bmask));

  p_idle_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == C_RD) |=> v1);

  p_mode_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MODE && accept) |-> !busy);

  p_oe_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);

endmodule

// File: tb/sdram_colburst_tb.sv
module sdram_colburst_tb_top;
  localparam int DW = 16;
  localparam int COL_W = 4;
  localparam int DEPTH = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic [1:0] cmd = 2'd0;
  logic [9:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [DEPTH];
  int lc = 0;
  bit il = 0, cl3 = 0, ws = 0;

  always #5 clk = ~clk;

  sdram_colburst #(.DW(DW), .COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

  function automatic int col_of(int s, int k);
    int len, base, so;
    len  = 1 << lc;
    base = s & ~(len - 1);
    so   = s & (len - 1);
    return il ? (base | (so ^ k)) : (base | ((so + k) % len));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic junk();
    cmd   = ($urandom % 2) ? 2'd1 : 2'd2;
    addr  = 10'($urandom);
    wdata = DW'($urandom);
  endtask

  task automatic do_mrs(int nlc, bit nil, bit ncl3, bit nws);
    @(negedge clk);
    cke = 1'b1;
    cmd = 2'd3;
    addr = '0;
    addr[1:0] = 2'(nlc);
    addr[2] = nil;
    addr[4] = ncl3;
    addr[9] = nws;
    @(posedge clk);
    lc = nlc; il = nil; cl3 = ncl3; ws = nws;
    @(negedge clk);
    cmd = 2'd0; addr = '0;
  endtask

  task automatic do_write(int col, bit sus, string tag);
    int len, t, tn;
    bit lowprev;
    logic [DW-1:0] w [8];
    len = ws ? 1 : (1 << lc);
    for (int k = 0; k < 8; k++) w[k] = DW'($urandom);
    @(negedge clk);
    cke = 1'b1; cmd = 2'd2; addr = 10'(col); wdata = w[0];
    @(posedge clk);
    t = 0; lowprev = 1'b0;
    while (t < len - 1) begin
      @(negedge clk);
      chk(tag, "rdata_oe during write", int'(rdata_oe), 0);
      tn = lowprev ? t : t + 1;
      if (lowprev) junk();
      else begin cmd = 2'd0; wdata = w[tn]; end
      cke = !(sus && tn < len - 1 && ($urandom % 3 == 0));
      @(posedge clk);
      t = tn; lowprev = !cke;
    end
    @(negedge clk);
    cmd = 2'd0; cke = 1'b1; addr = '0;
    for (int k = 0; k < len; k++) shadow[col_of(col, k)] = w[k];
  endtask

  task automatic do_read(int col, bit sus, string tag);
    int len, cl, t, tn, eoe, ed;
    bit lowprev;
    len = 1 << lc;
    cl = cl3 ? 3 : 2;
    @(negedge clk);
    cke = 1'b1; cmd = 2'd1; addr = 10'(col);
    @(posedge clk);
    t = 0; lowprev = 1'b0;
    forever begin
      @(negedge clk);
      if (t >= cl && t < cl + len) begin
        eoe = 1; ed = int'(shadow[col_of(col, t - cl)]);
      end else begin
        eoe = 0; ed = 0;
      end
      chk(tag, "rdata_oe", int'(rdata_oe), eoe);
      chk(tag, "rdata", int'(rdata), ed);
      if (t >= cl + len) break;
      tn = lowprev ? t : t + 1;
      if (lowprev) junk();
      else begin cmd = 2'd0; addr = '0; end
      cke = !(sus && tn < len - 1 && ($urandom % 3 == 0));
      @(posedge clk);
      t = tn; lowprev = !cke;
    end
    cmd = 2'd0; cke = 1'b1; addr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "rdata_oe after reset", int'(rdata_oe), 0);
    chk("R1", "rdata after reset", int'(rdata), 0);

    // R1: default mode gives one-word bursts at latency 2
    do_read(9, 1'b0, "R1");
    do_write(5, 1'b0, "R1");
    do_read(5, 1'b0, "R1");
    do_read(4, 1'b0, "R1");

    // R2 R5: eight-word sequential fill of the whole array
    do_mrs(3, 1'b0, 1'b0, 1'b0);
    do_write(0, 1'b0, "R5");
    do_write(8, 1'b0, "R5");
    do_read(3, 1'b0, "R4");
    do_read(14, 1'b0, "R2");

    // R4: interleaved order, latency 3
    do_mrs(3, 1'b1, 1'b1, 1'b0);
    do_read(5, 1'b0, "R4");
    do_write(13, 1'b0, "R4");
    do_read(8, 1'b0, "R4");
    do_mrs(2, 1'b1, 1'b0, 1'b0);
    do_read(6, 1'b0, "R4");

    // R6: single-column writes, reads still burst
    do_mrs(2, 1'b0, 1'b0, 1'b1);
    do_write(9, 1'b0, "R6");
    @(negedge clk); wdata = DW'($urandom);
    @(negedge clk); wdata = DW'($urandom);
    do_read(8, 1'b0, "R6");

    // R7: a READ one edge after another truncates the first
    do_mrs(2, 1'b0, 1'b0, 1'b0);
    @(negedge clk); cmd = 2'd1; addr = 10'd1;
    @(posedge clk);
    @(negedge clk); cmd = 2'd1; addr = 10'd6;
    chk("R7", "rdata_oe t0", int'(rdata_oe), 0);
    @(posedge clk);
    @(negedge clk); cmd = 2'd0; addr = '0;
    chk("R7", "rdata_oe t1", int'(rdata_oe), 0);
    for (int e = 2; e <= 7; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 2) begin
        chk("R7", "old word", int'(rdata), int'(shadow[1]));
        chk("R7", "old oe", int'(rdata_oe), 1);
      end else if (e <= 6) begin
        chk("R7", "new word", int'(rdata), int'(shadow[4 + ((2 + e - 3) % 4)]));
        chk("R7", "new oe", int'(rdata_oe), 1);
      end else begin
        chk("R7", "end oe", int'(rdata_oe), 0);
      end
    end

    // R10: low cke while idle does not block commands
    do_mrs(0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); cke = 1'b0;
    @(posedge clk);
    do_write(7, 1'b0, "R10");
    @(negedge clk); cke = 1'b0;
    @(posedge clk);
    do_read(7, 1'b0, "R10");

    // R8 R9: suspended bursts in a fixed mode
    do_mrs(3, 1'b0, 1'b0, 1'b0);
    do_write(2, 1'b1, "R8");
    do_read(2, 1'b1, "R8");
    do_read(10, 1'b1, "R9");

    for (int it = 0; it < 150; it++) begin
      do_mrs(int'($urandom % 4), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
      do_write(int'($urandom % DEPTH), 1'b1, "R5/R8/R9");
      do_read(int'($urandom % DEPTH), 1'b1, "R3/R4/R8/R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule